// File: doc/BRIEF.md
# Check-byte window RAM wrapper

This block wraps a small 64-bit-wide data memory protected by an 8-bit single-error-correct, double-error-detect code. Every normal write stores the data word and the check byte the block computes from it. Every normal read recomputes the syndrome, returns corrected data and reports whether a single error was repaired or an uncorrectable error was seen. A write with only some byte strobes set merges the new lanes into the old (corrected) word and then regenerates the check byte, all in the same cycle.

A second address window aliases the check-byte array, so diagnostic software can read the stored codes and deliberately corrupt them to exercise the error paths. Each check byte occupies an 8-byte step of that window. Window reads return the raw byte on all eight lanes. Window writes only land when an enable bit in a small control register is set and all eight strobes are on.

Top module: `ecc_window_ram`

## Requirements
- R1: A read request (req_valid=1, req_write=0) yields rsp_valid=1 with the read data in the following cycle; rsp_valid is 0 in every cycle that does not follow a read request. A full write followed by a normal read of the same word returns the written data with rsp_fixed=0 and rsp_uncorr=0.
- R2: A normal write stores, for its word index, the check byte {P, H[6:0]}: data bit j is placed at codeword position j-th non-power-of-two in 1..71, H[i] is the XOR of the data bits whose position has bit i set, and P is the XOR of all 64 data bits and all seven H bits.
- R3: A read in the check window returns the stored check byte copied onto all eight byte lanes, raw, with rsp_fixed=0 and rsp_uncorr=0.
- R4: Address bit 7 selects the check window (1) or the data array (0); bits [6:3] give the word index, so window offset 8*n holds the check byte of data word n.
- R5: An accepted window write stores req_wdata[7:0] as the check byte; bits [63:8] are ignored and the data array is not changed.
- R6: A window write while the enable bit is clear leaves the check byte unchanged.
- R7: A window write whose strobe is not 8'hFF leaves the check byte unchanged, even with the enable bit set.
- R8: When stored data and check byte differ from a valid codeword in one bit, a normal read returns the corrected word with rsp_fixed=1 and rsp_uncorr=0.
- R9: When they differ in two bits, a normal read gives rsp_uncorr=1 and rsp_fixed=0.
- R10: A normal write with strobe s replaces byte lane k (bits 8k+7..8k) when s[k]=1, keeps the old lane otherwise, and stores the check byte of the merged word.
- R11: After reset the enable bit is 0, rsp_valid is 0, and every data word and check byte is 0.
- R12: A cycle with cfg_wr=1 loads cfg_wdata[8] into the enable bit, visible on ecc_wr_en in the next cycle; other cfg_wdata bits have no effect.

Top module port order follows below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 16 | Control register write value; bit 8 is the check-window write enable |
| ecc_wr_en | output | 1 | Current check-window write enable |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Byte address; bit 7 window select, bits 6:3 word index |
| req_strb | input | 8 | Byte-lane write strobes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| rsp_fixed | output | 1 | A single error was corrected in this read |
| rsp_uncorr | output | 1 | An uncorrectable error was detected in this read |

## Verification
Read results are registered once, so they are due exactly one cycle after the request; writes and control updates take effect at the edge that accepts them and are visible to a read issued in the next cycle. The bench drives every request on a falling edge and samples the response on the next falling edge, half a cycle after the register that produces it. Error paths are reached by writing, through the window, check bytes that the bench computed for the stored word with one or two data or check bits flipped.

// File: rtl/ewr_pkg.sv
package ewr_pkg;

    localparam int DATA_W = 64;
    localparam int HAM_W  = 7;
    localparam int CHK_W  = HAM_W + 1;
    localparam int CW_LEN = DATA_W + HAM_W;

    // Hamming bits: XOR of the codeword positions of all set data bits.
    function automatic logic [HAM_W-1:0] ewr_hamming(logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] h;
        int               di;
        h  = '0;
        di = 0;
        for (int p = 1; p <= CW_LEN; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (d[di]) h ^= HAM_W'(p);
                di++;
            end
        end
        return h;
    endfunction

    // Data-bit mask selected by a syndrome (zero when it names a check bit).
    function automatic logic [DATA_W-1:0] ewr_flip(logic [HAM_W-1:0] syn);
        logic [DATA_W-1:0] m;
        int                di;
        m  = '0;
        di = 0;
        for (int p = 1; p <= CW_LEN; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (HAM_W'(p) == syn) m[di] = 1'b1;
                di++;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/ewr_secded_enc.sv
module ewr_secded_enc
    import ewr_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);
    logic [HAM_W-1:0] ham;

    always_comb begin
        ham   = ewr_hamming(data_i);
        chk_o = {(^data_i) ^ (^ham), ham};
    end
endmodule

// File: rtl/ewr_secded_dec.sv
module ewr_secded_dec
    import ewr_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  chk_i,
    output logic [DATA_W-1:0] data_o,
    output logic              fixed_o,
    output logic              uncorr_o
);
    logic [HAM_W-1:0] syn;
    logic             par_err;

    always_comb begin
        syn      = ewr_hamming(data_i) ^ chk_i[HAM_W-1:0];
        par_err  = (^data_i) ^ (^chk_i);
        fixed_o  = par_err;
        uncorr_o = !par_err && (syn != '0);
        data_o   = par_err ? (data_i ^ ewr_flip(syn)) : data_i;
    end
endmodule

// File: rtl/ecc_window_ram.sv
module ecc_window_ram
    import ewr_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int EN_BIT = 8,
    parameter int CFG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic              ecc_wr_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [$clog2(DEPTH)+3:0] req_addr,
    input  logic [DATA_W/8-1:0] req_strb,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_fixed,
    output logic              rsp_uncorr
);
    localparam int LANES   = DATA_W / 8;
    localparam int IDX_W   = $clog2(DEPTH);
    localparam int IDX_LSB = $clog2(LANES);
    localparam int WIN_BIT = IDX_W + IDX_LSB;

    typedef struct {
        logic                            en;
        logic                            rv;
        logic [DATA_W-1:0]               rd;
        logic                            fx;
        logic                            un;
        logic [DEPTH-1:0][DATA_W-1:0]    dm;
        logic [DEPTH-1:0][CHK_W-1:0]     cm;
    } st_t;

    st_t s_d, s_q;

    logic [IDX_W-1:0]  idx;
    logic              win;
    logic [DATA_W-1:0] cor_data, merged;
    logic              cor_fix, cor_unc;
    logic [CHK_W-1:0]  new_chk;

    assign idx = req_addr[IDX_LSB +: IDX_W];
    assign win = req_addr[WIN_BIT];

    ewr_secded_dec dec_i (
        .data_i   (s_q.dm[idx]),
        .chk_i    (s_q.cm[idx]),
        .data_o   (cor_data),
        .fixed_o  (cor_fix),
        .uncorr_o (cor_unc)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign merged[8*k +: 8] = req_strb[k] ? req_wdata[8*k +: 8] : cor_data[8*k +: 8];
    end

    ewr_secded_enc enc_i (
        .data_i (merged),
        .chk_o  (new_chk)
    );

    always_comb begin
        s_d    = s_q;
        s_d.rv = 1'b0;
        if (cfg_wr) s_d.en = cfg_wdata[EN_BIT];
        if (req_valid && req_write) begin
            if (win) begin
                if (s_q.en && (req_strb == '1)) s_d.cm[idx] = req_wdata[CHK_W-1:0];
            end else begin
                s_d.dm[idx] = merged;
                s_d.cm[idx] = new_chk;
            end
        end
        if (req_valid && !req_write) begin
            s_d.rv = 1'b1;
            if (win) begin
                s_d.rd = {LANES{s_q.cm[idx]}};
                s_d.fx = 1'b0;
                s_d.un = 1'b0;
            end else begin
                s_d.rd = cor_data;
                s_d.fx = cor_fix;
                s_d.un = cor_unc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.en <= 1'b0;
            s_q.rv <= 1'b0;
            s_q.rd <= '0;
            s_q.fx <= 1'b0;
            s_q.un <= 1'b0;
            s_q.dm <= '0;
            s_q.cm <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ecc_wr_en  = s_q.en;
    assign rsp_valid  = s_q.rv;
    assign rsp_rdata  = s_q.rd;
    assign rsp_fixed  = s_q.fx;
    assign rsp_uncorr = s_q.un;

    logic [DEPTH*CHK_W-1:0]  chk_flat;
    logic [DEPTH*DATA_W-1:0] data_flat;
    assign chk_flat  = s_q.cm;
    assign data_flat = s_q.dm;

    p_rsp_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);
    p_no_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);
    p_win_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && win) |=>
            (rsp_rdata == {LANES{rsp_rdata[7:0]}}) && !rsp_fixed && !rsp_uncorr);
    p_win_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && win) |=> $stable(data_flat));
    p_win_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && win && !ecc_wr_en) |=> $stable(chk_flat));
    p_win_strb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && win && (req_strb != '1)) |=> $stable(chk_flat));
    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_fixed && rsp_uncorr));
    p_cfg_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (ecc_wr_en == $past(cfg_wdata[EN_BIT])));
    p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(ecc_wr_en));
endmodule

// File: tb/ecc_window_ram_tb_top.sv
module ecc_window_ram_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        ecc_wr_en;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [7:0]  req_strb = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_fixed, rsp_uncorr;
    logic [63:0] rsp_rdata;

    int n_chk = 0, n_fail = 0;
    logic [63:0] pats [16];

    always #5 clk = ~clk;

    ecc_window_ram dut_i (.*);

    function automatic logic [7:0] ref_code(logic [63:0] d);
        logic [6:0] h;
        int pos;
        h = '0;
        pos = 3;
        for (int j = 0; j < 64; j++) begin
            while ((pos & (pos - 1)) == 0) pos++;
            for (int i = 0; i < 7; i++) if (((pos >> i) & 1) == 1) h[i] = h[i] ^ d[j];
            pos++;
        end
        return {(^d) ^ (^h), h};
    endfunction

    function automatic logic [7:0] daddr(int i); return {1'b0, 4'(i), 3'b000}; endfunction
    function automatic logic [7:0] waddr(int i); return {1'b1, 4'(i), 3'b000}; endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] s, input logic [63:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_strb = s; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d, output logic f, output logic u);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        check(rsp_valid, "R1 rsp_valid", 64'(rsp_valid), 64'd1);
        d = rsp_rdata; f = rsp_fixed; u = rsp_uncorr;
        req_valid = 0;
    endtask

    task automatic cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_wr = 1; cfg_wdata = v;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    initial begin
        #1500000;
        n_chk++; n_fail++;
        $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] d, e;
        logic f, u;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R11 reset state
        check(!rsp_valid, "R11 rsp_valid", 64'(rsp_valid), 0);
        check(!ecc_wr_en, "R11 enable", 64'(ecc_wr_en), 0);
        rd(daddr(0), d, f, u);
        check(d == 0 && !f && !u, "R11 data word", d, 0);
        rd(waddr(15), d, f, u);
        check(d == 0, "R11 check byte", d, 0);
        @(negedge clk);
        check(!rsp_valid, "R1 idle no rsp", 64'(rsp_valid), 0);

        // R12 control bit
        cfg(16'hFEFF);
        check(!ecc_wr_en, "R12 other bits", 64'(ecc_wr_en), 0);
        cfg(16'h0100);
        check(ecc_wr_en, "R12 set", 64'(ecc_wr_en), 1);
        cfg(16'h0000);
        check(!ecc_wr_en, "R12 clear", 64'(ecc_wr_en), 0);

        // R1 R2 R4 full sweep of all words
        for (int i = 0; i < 16; i++) begin
            pats[i] = 64'h0123456789ABCDEF ^ (64'(i + 1) * 64'h9E3779B97F4A7C15);
            wr(daddr(i), 8'hFF, pats[i]);
        end
        for (int i = 0; i < 16; i++) begin
            rd(daddr(i), d, f, u);
            check(d == pats[i] && !f && !u, "R1 readback", d, pats[i]);
            rd(waddr(i), d, f, u);
            e = {8{ref_code(pats[i])}};
            check(d == e && !f && !u, "R2 R3 R4 window code", d, e);
        end

        // R6 enable clear blocks window write
        wr(waddr(3), 8'hFF, 64'h55);
        rd(waddr(3), d, f, u);
        e = {8{ref_code(pats[3])}};
        check(d == e, "R6 blocked", d, e);

        cfg(16'h0100);
        // R7 partial strobes blocked
        for (int s = 0; s < 255; s++) begin
            wr(waddr(4), 8'(s), ~{8{ref_code(pats[4])}});
            rd(waddr(4), d, f, u);
            e = {8{ref_code(pats[4])}};
            check(d == e, "R7 strobe blocked", d, e);
        end

        // R5 low byte stored, rest ignored, data untouched
        wr(waddr(5), 8'hFF, 64'hDEADBEEF_123456A5);
        rd(waddr(5), d, f, u);
        check(d == {8{8'hA5}}, "R5 low byte", d, {8{8'hA5}});
        wr(waddr(5), 8'hFF, {56'hFFFF_FFFF_FFFF_FF, ref_code(pats[5])});
        rd(daddr(5), d, f, u);
        check(d == pats[5] && !f && !u, "R5 data untouched", d, pats[5]);

        // R8 single-bit data errors
        for (int k = 0; k < 64; k++) begin
            e = pats[6] ^ (64'd1 << k);
            wr(waddr(6), 8'hFF, 64'(ref_code(e)));
            rd(daddr(6), d, f, u);
            check(d == e && f && !u, "R8 data bit fix", d, e);
        end
        for (int b = 0; b < 8; b++) begin
            wr(waddr(6), 8'hFF, 64'(ref_code(pats[6]) ^ 8'(1 << b)));
            rd(daddr(6), d, f, u);
            check(d == pats[6] && f && !u, "R8 check bit fix", d, pats[6]);
        end
        // R9 double errors
        for (int k = 0; k < 63; k++) begin
            e = pats[6] ^ (64'd3 << k);
            wr(waddr(6), 8'hFF, 64'(ref_code(e)));
            rd(daddr(6), d, f, u);
            check(u && !f, "R9 double data", {62'd0, f, u}, 64'd1);
        end
        wr(waddr(6), 8'hFF, 64'(ref_code(pats[6]) ^ 8'h81));
        rd(daddr(6), d, f, u);
        check(u && !f, "R9 double check", {62'd0, f, u}, 64'd1);

        // R10 partial write merge over all strobes
        for (int s = 0; s < 256; s++) begin
            wr(daddr(7), 8'hFF, pats[7]);
            wr(daddr(7), 8'(s), pats[8]);
            for (int k = 0; k < 8; k++)
                e[8*k +: 8] = s[k] ? pats[8][8*k +: 8] : pats[7][8*k +: 8];
            rd(daddr(7), d, f, u);
            check(d == e && !f && !u, "R10 merge", d, e);
            rd(waddr(7), d, f, u);
            check(d == {8{ref_code(e)}}, "R10 code", d, {8{ref_code(e)}});
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule